// File: doc/BRIEF.md
# Minimum Response Latency Enforcer

This block sits on the read-data and write-response channels between an AXI master and its slave. It makes sure that no response reaches the master sooner than a configured number of cycles after the event that started it. The start of a read is the cycle in which its address handshake completes. The start of a write is the cycle in which the final write-data beat is accepted. Each start time is taken from a free-running cycle counter and stored in a per-channel queue. When the slave offers the matching response, the block compares the current count against the stored one. Modular subtraction keeps that comparison correct across counter wrap.

A response that arrives too early is held. While it is held, valid toward the master and ready toward the slave are both low. A response that arrives after its earliest allowed cycle passes at once and is reported on a one-cycle underrun pulse. Responses are assumed to return in order on each channel. Only the first beat of a read burst is timed. Address and write-data payloads travel outside this block: only their valid, ready and last wires pass through it, so that the queues can apply backpressure when they fill. Latencies are 12-bit cycle counts. The timestamp width `TS_W` must exceed the latency width and must cover the longest lifetime of a queued transaction.

Top module: `latency_enforcer`

## Requirements
- R1: After reset both queues are empty and both underrun outputs are low. With a nonzero latency configured, an offered response is not passed: valid toward the master and ready toward the slave are both 0. Address and write-data ready toward the master follow the slave's ready.
- R2: With read latency L > 0 and an address handshake in cycle 0, the first beat of the read is visible to the master in cycle max(L, d). Here d is the first cycle in which the slave offers it.
- R3: While a response is being held, `m_rvalid`/`m_bvalid` is 0 and `s_rready`/`s_bready` is 0.
- R4: After the first beat of a read burst has been handed over, the remaining beats pass in the same cycle the slave offers them, until the beat with last = 1.
- R5: With write latency L > 0 and the final write beat (valid, ready and last all 1) accepted in cycle 0, the write response is visible to the master in cycle max(L, d). Here d is the first cycle the slave offers it.
- R6: A latency setting of 0 passes responses in the cycle the slave offers them and never raises an underrun.
- R7: When the latency is nonzero and a read first beat or a write response is handed to the master after its earliest allowed cycle, `rd_underrun`/`wr_underrun` is 1 for exactly the next cycle. This applies whether the lateness comes from the slave or from master backpressure. A handover in exactly the earliest cycle raises nothing.
- R8: Start times are queued in order, `DEPTH` per channel (default 4), and each transaction is timed from its own start. With `DEPTH` transactions outstanding on a channel, address valid (or write valid) toward the slave and ready toward the master are both 0 until a response leaves.
- R9: Read data, read last and write response code are forwarded unchanged. A response is never shown to the master unless the slave offers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_lat | input | LAT_W (12) | Minimum read latency in cycles |
| cfg_wr_lat | input | LAT_W (12) | Minimum write latency in cycles |
| m_arvalid | input | 1 | Read address valid from master |
| m_arready | output | 1 | Read address ready to master |
| s_arvalid | output | 1 | Read address valid to slave |
| s_arready | input | 1 | Read address ready from slave |
| m_wvalid | input | 1 | Write data valid from master |
| m_wlast | input | 1 | Final write beat marker from master |
| m_wready | output | 1 | Write data ready to master |
| s_wvalid | output | 1 | Write data valid to slave |
| s_wready | input | 1 | Write data ready from slave |
| s_rvalid | input | 1 | Read data valid from slave |
| s_rdata | input | DATA_W (64) | Read data from slave |
| s_rlast | input | 1 | Final read beat from slave |
| s_rready | output | 1 | Read data ready to slave |
| m_rvalid | output | 1 | Read data valid to master |
| m_rdata | output | DATA_W (64) | Read data to master |
| m_rlast | output | 1 | Final read beat to master |
| m_rready | input | 1 | Read data ready from master |
| s_bvalid | input | 1 | Write response valid from slave |
| s_bresp | input | RESP_W (2) | Write response code from slave |
| s_bready | output | 1 | Write response ready to slave |
| m_bvalid | output | 1 | Write response valid to master |
| m_bresp | output | RESP_W (2) | Write response code to master |
| m_bready | input | 1 | Write response ready from master |
| rd_underrun | output | 1 | One-cycle pulse: a read missed its deadline |
| wr_underrun | output | 1 | One-cycle pulse: a write missed its deadline |

## Verification
The hardest state to reach is a queue holding several start times at once, where the response for a younger transaction must be timed from its own stamp rather than from the one just retired. A second hard case is an underrun that comes from the master's ready rather than from the slave. The stimulus issues two read addresses in consecutive cycles while the slave offers data continuously, and expects the handovers one cycle apart. It also fills a queue to its depth with addresses alone, to see the address path close. A table of single transactions walks early, exact and late arrivals on both channels, including a held master ready that turns an on-time response into a late one.

// File: rtl/lat_enf_pkg.sv
package lat_enf_pkg;

    typedef enum logic {
        CH_READ  = 1'b0,
        CH_WRITE = 1'b1
    } chan_kind_e;

    // Combinational view of one response gate in the current cycle.
    typedef struct packed {
        logic open;   // response may pass this cycle
        logic first;  // the next beat starts a new transaction
        logic late;   // handing over now would miss the deadline
    } gate_view_t;

endpackage

// File: rtl/cycle_stamp.sv
module cycle_stamp #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end
endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/resp_gate.sv
module resp_gate
    import lat_enf_pkg::*;
#(
    parameter chan_kind_e KIND  = CH_READ,
    parameter int         LAT_W = 12,
    parameter int         TS_W  = 16,
    parameter int         DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAT_W-1:0] lat,
    input  logic [TS_W-1:0]  now,
    input  logic             start_evt,
    output logic             slot_full,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic             m_valid,
    input  logic             m_ready,
    output logic             underrun
);
    logic [TS_W-1:0] head, elapsed, lat_ext;
    logic            empty, bypass, ripe_now, ripe_q, in_burst, fire, pop;
    gate_view_t      view;

    stamp_fifo #(.DEPTH(DEPTH), .W(TS_W)) u_stamps (
        .clk   (clk),
        .rst   (rst),
        .push  (start_evt),
        .din   (now),
        .pop   (pop),
        .head  (head),
        .empty (empty),
        .full  (slot_full)
    );

    assign lat_ext  = {{(TS_W-LAT_W){1'b0}}, lat};
    assign elapsed  = now - head;
    assign bypass   = (lat == '0);
    assign ripe_now = !empty && (elapsed >= lat_ext);

    always_comb begin
        view.first = !in_burst;
        view.open  = in_burst || bypass || ripe_now || ripe_q;
        view.late  = ripe_q || (ripe_now && (elapsed != lat_ext));
    end

    assign m_valid = s_valid && view.open;
    assign s_ready = m_ready && view.open;
    assign fire    = m_valid && m_ready;
    assign pop     = fire && view.first && !empty;

    generate
        if (KIND == CH_READ) begin : g_burst
            logic burst_q;
            always_ff @(posedge clk) begin
                if (rst)       burst_q <= 1'b0;
                else if (fire) burst_q <= !s_last;
            end
            assign in_burst = burst_q;
        end else begin : g_single
            logic unused_last;
            assign unused_last = s_last;
            assign in_burst    = 1'b0;
        end
    endgenerate

    // ripe_q remembers that the head's deadline has come, surviving counter wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            ripe_q   <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= pop && !bypass && view.late;
            if (pop)                      ripe_q <= 1'b0;
            else if (!empty && ripe_now)  ripe_q <= 1'b1;
        end
    end

    assert_hold_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (!bypass && empty && !in_burst) |-> (!m_valid && !s_ready));
    assert_burst_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (in_burst && s_valid) |-> m_valid);
    assert_offered_only_R9: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> s_valid);
    assert_underrun_cause_R7: assert property (@(posedge clk) disable iff (rst)
        underrun |-> ($past(fire) && $past(lat != '0)));

endmodule

// File: rtl/latency_enforcer.sv
module latency_enforcer
    import lat_enf_pkg::*;
#(
    parameter int LAT_W  = 12,
    parameter int TS_W   = 16,
    parameter int DEPTH  = 4,
    parameter int DATA_W = 64,
    parameter int RESP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LAT_W-1:0]  cfg_rd_lat,
    input  logic [LAT_W-1:0]  cfg_wr_lat,
    input  logic              m_arvalid,
    output logic              m_arready,
    output logic              s_arvalid,
    input  logic              s_arready,
    input  logic              m_wvalid,
    input  logic              m_wlast,
    output logic              m_wready,
    output logic              s_wvalid,
    input  logic              s_wready,
    input  logic              s_rvalid,
    input  logic [DATA_W-1:0] s_rdata,
    input  logic              s_rlast,
    output logic              s_rready,
    output logic              m_rvalid,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_rlast,
    input  logic              m_rready,
    input  logic              s_bvalid,
    input  logic [RESP_W-1:0] s_bresp,
    output logic              s_bready,
    output logic              m_bvalid,
    output logic [RESP_W-1:0] m_bresp,
    input  logic              m_bready,
    output logic              rd_underrun,
    output logic              wr_underrun
);
    logic [TS_W-1:0] now;
    logic            rd_full, wr_full, rd_start, wr_start;

    cycle_stamp #(.TS_W(TS_W)) u_clock (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    assign s_arvalid = m_arvalid && !rd_full;
    assign m_arready = s_arready && !rd_full;
    assign rd_start  = m_arvalid && s_arready && !rd_full;

    assign s_wvalid  = m_wvalid && !wr_full;
    assign m_wready  = s_wready && !wr_full;
    assign wr_start  = m_wvalid && m_wlast && s_wready && !wr_full;

    assign m_rdata   = s_rdata;
    assign m_rlast   = s_rlast;
    assign m_bresp   = s_bresp;

    resp_gate #(.KIND(CH_READ), .LAT_W(LAT_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_rd_gate (
        .clk       (clk),
        .rst       (rst),
        .lat       (cfg_rd_lat),
        .now       (now),
        .start_evt (rd_start),
        .slot_full (rd_full),
        .s_valid   (s_rvalid),
        .s_last    (s_rlast),
        .s_ready   (s_rready),
        .m_valid   (m_rvalid),
        .m_ready   (m_rready),
        .underrun  (rd_underrun)
    );

    resp_gate #(.KIND(CH_WRITE), .LAT_W(LAT_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_wr_gate (
        .clk       (clk),
        .rst       (rst),
        .lat       (cfg_wr_lat),
        .now       (now),
        .start_evt (wr_start),
        .slot_full (wr_full),
        .s_valid   (s_bvalid),
        .s_last    (1'b1),
        .s_ready   (s_bready),
        .m_valid   (m_bvalid),
        .m_ready   (m_bready),
        .underrun  (wr_underrun)
    );

    assert_ar_closed_R8: assert property (@(posedge clk) disable iff (rst)
        (m_arvalid && s_arready && !m_arready) |-> !s_arvalid);
    assert_w_closed_R8: assert property (@(posedge clk) disable iff (rst)
        (m_wvalid && s_wready && !m_wready) |-> !s_wvalid);

endmodule

// File: tb/test_latency_enforcer.sv
`timescale 1ns/100ps
module test_latency_enforcer;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] cfg_rd_lat, cfg_wr_lat;
    logic        m_arvalid, s_arready, m_wvalid, m_wlast, s_wready;
    logic        m_arready, s_arvalid, m_wready, s_wvalid;
    logic        s_rvalid, s_rlast, m_rready, s_bvalid, m_bready;
    logic [63:0] s_rdata, m_rdata;
    logic [1:0]  s_bresp, m_bresp;
    logic        s_rready, m_rvalid, m_rlast, s_bready, m_bvalid;
    logic        rd_underrun, wr_underrun;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    latency_enforcer i_latency_enforcer (
        .clk(clk), .rst(rst), .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .m_wvalid(m_wvalid), .m_wlast(m_wlast), .m_wready(m_wready), .s_wvalid(s_wvalid),
        .s_wready(s_wready), .s_rvalid(s_rvalid), .s_rdata(s_rdata), .s_rlast(s_rlast),
        .s_rready(s_rready), .m_rvalid(m_rvalid), .m_rdata(m_rdata), .m_rlast(m_rlast),
        .m_rready(m_rready), .s_bvalid(s_bvalid), .s_bresp(s_bresp), .s_bready(s_bready),
        .m_bvalid(m_bvalid), .m_bresp(m_bresp), .m_bready(m_bready),
        .rd_underrun(rd_underrun), .wr_underrun(wr_underrun)
    );

    // ch: 0 read, 1 write; dly: first cycle slave offers; rdy: first cycle master ready
    typedef struct packed {
        logic [15:0] ch, lat, dly, beats, rdy, exp_first, exp_und;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'd0, 16'd5,  16'd1,  16'd1, 16'd1, 16'd5,  16'd0},
        '{16'd0, 16'd5,  16'd8,  16'd1, 16'd1, 16'd8,  16'd1},
        '{16'd0, 16'd0,  16'd1,  16'd1, 16'd1, 16'd1,  16'd0},
        '{16'd0, 16'd0,  16'd4,  16'd1, 16'd1, 16'd4,  16'd0},
        '{16'd0, 16'd3,  16'd3,  16'd4, 16'd1, 16'd3,  16'd0},
        '{16'd0, 16'd2,  16'd1,  16'd1, 16'd6, 16'd2,  16'd1},
        '{16'd1, 16'd7,  16'd2,  16'd1, 16'd1, 16'd7,  16'd0},
        '{16'd1, 16'd2,  16'd6,  16'd1, 16'd1, 16'd6,  16'd1},
        '{16'd1, 16'd0,  16'd2,  16'd1, 16'd1, 16'd2,  16'd0},
        '{16'd1, 16'd12, 16'd12, 16'd1, 16'd1, 16'd12, 16'd0},
        '{16'd0, 16'd1,  16'd1,  16'd2, 16'd1, 16'd1,  16'd0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        m_arvalid = 0; s_arready = 1; m_wvalid = 0; m_wlast = 0; s_wready = 1;
        s_rvalid = 0; s_rlast = 0; s_rdata = '0; m_rready = 0;
        s_bvalid = 0; s_bresp = 2'b00; m_bready = 0;
    endtask

    task automatic run_txn(input vec_t v, input int row);
        int first_seen = -1;
        int beat = 0;
        int und = 0;
        int other_und = 0;
        int k = 1;
        bit done = 0, hold_bad = 0, burst_bad = 0, data_bad = 0;
        bit mv, sr, ready;
        string req_lat, req_h;
        req_lat = (v.lat == 0) ? "R6" : ((v.ch == 0) ? "R2" : "R5");
        if (v.ch == 0) cfg_rd_lat = v.lat[11:0]; else cfg_wr_lat = v.lat[11:0];
        @(posedge clk); #1;
        if (v.ch == 0) m_arvalid = 1; else begin m_wvalid = 1; m_wlast = 1; end
        @(posedge clk); #1;
        m_arvalid = 0; m_wvalid = 0; m_wlast = 0;
        while (!done && k < 6000) begin
            ready = (k >= int'(v.rdy));
            if (v.ch == 0) begin
                s_rvalid = (k >= int'(v.dly));
                s_rlast  = (beat == int'(v.beats) - 1);
                s_rdata  = {32'hC0DE0000 + 32'(row), 32'(beat)};
                m_rready = ready;
            end else begin
                s_bvalid = (k >= int'(v.dly));
                s_bresp  = 2'b10;
                m_bready = ready;
            end
            #2;
            mv = (v.ch == 0) ? m_rvalid : m_bvalid;
            sr = (v.ch == 0) ? s_rready : s_bready;
            if (v.ch == 0) begin und += rd_underrun; other_und += wr_underrun; end
            else begin und += wr_underrun; other_und += rd_underrun; end
            if (mv && first_seen < 0) first_seen = k;
            if (k < int'(v.exp_first) && mv) hold_bad = 1;
            if (v.lat != 0 && k < int'(v.lat) && sr) hold_bad = 1;
            if (beat > 0 && !mv) burst_bad = 1;
            if (mv && ready) begin
                if (v.ch == 0 && (m_rdata != s_rdata || m_rlast != s_rlast)) data_bad = 1;
                if (v.ch == 1 && m_bresp != s_bresp) data_bad = 1;
                beat++;
                if (beat == int'(v.beats)) done = 1;
            end
            @(posedge clk); #1;
            k++;
        end
        idle_inputs();
        for (int j = 0; j < 2; j++) begin
            #2;
            if (v.ch == 0) begin und += rd_underrun; other_und += wr_underrun; end
            else begin und += wr_underrun; other_und += rd_underrun; end
            @(posedge clk); #1;
        end
        check(first_seen == int'(v.exp_first), req_lat, $sformatf("row %0d first visible cycle", row),
              first_seen, v.exp_first);
        req_h = "R3";
        check(!hold_bad, req_h, $sformatf("row %0d held response leaked", row), hold_bad, 0);
        if (v.beats > 1)
            check(!burst_bad, "R4", $sformatf("row %0d later beat delayed", row), burst_bad, 0);
        check(!data_bad, "R9", $sformatf("row %0d payload forwarded", row), data_bad, 0);
        check(und == int'(v.exp_und), (v.lat == 0) ? "R6" : "R7",
              $sformatf("row %0d underrun pulses", row), und, v.exp_und);
        check(other_und == 0, "R7", $sformatf("row %0d other channel underrun", row), other_und, 0);
    endtask

    initial begin
        #1000000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int hs [2];
        int nhs;
        int drained;
        idle_inputs();
        cfg_rd_lat = 12'd5;
        cfg_wr_lat = 12'd3;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state with responses offered before any start event
        s_rvalid = 1; s_rlast = 1; m_rready = 1; s_bvalid = 1; m_bready = 1;
        #2;
        check(!m_rvalid && !s_rready, "R1", "read held after reset", {m_rvalid, s_rready}, 0);
        check(!m_bvalid && !s_bready, "R1", "write held after reset", {m_bvalid, s_bready}, 0);
        check(!rd_underrun && !wr_underrun, "R1", "underrun low after reset",
              {rd_underrun, wr_underrun}, 0);
        check(m_arready && m_wready, "R1", "address and data ready open", {m_arready, m_wready}, 3);
        @(posedge clk); #1;
        idle_inputs();

        for (int i = 0; i < NV; i++) run_txn(VECS[i], i);

        // R8: two reads back to back, each timed from its own stamp
        cfg_rd_lat = 12'd4;
        nhs = 0;
        @(posedge clk); #1 m_arvalid = 1;
        @(posedge clk); #1;
        for (int k = 1; k <= 10; k++) begin
            if (k > 1) m_arvalid = 0;
            s_rvalid = (nhs < 2); s_rlast = 1; m_rready = 1;
            #2;
            if (m_rvalid && m_rready && nhs < 2) begin hs[nhs] = k; nhs++; end
            check(!rd_underrun, "R8", "no underrun on queued reads", rd_underrun, 0);
            @(posedge clk); #1;
        end
        idle_inputs();
        check(nhs == 2 && hs[0] == 4, "R8", "first queued read cycle", hs[0], 4);
        check(nhs == 2 && hs[1] == 5, "R8", "second queued read cycle", hs[1], 5);

        // R8: read queue full closes the address path
        cfg_rd_lat = 12'd1;
        @(posedge clk); #1 m_arvalid = 1;
        repeat (4) begin @(posedge clk); #1; end
        #2;
        check(!m_arready && !s_arvalid, "R8", "address path closed when full",
              {m_arready, s_arvalid}, 0);
        @(posedge clk); #1;
        m_arvalid = 0;
        drained = 0;
        for (int k = 0; k < 20 && drained < 4; k++) begin
            s_rvalid = 1; s_rlast = 1; m_rready = 1;
            #2;
            if (m_rvalid) drained++;
            @(posedge clk); #1;
        end
        idle_inputs();
        #2;
        check(drained == 4 && m_arready, "R8", "address path reopens after drain", drained, 4);
        @(posedge clk); #1;

        // R8: write queue full closes the write-data path
        cfg_wr_lat = 12'd1;
        m_wvalid = 1; m_wlast = 1;
        repeat (4) begin @(posedge clk); #1; end
        #2;
        check(!m_wready && !s_wvalid, "R8", "write path closed when full", {m_wready, s_wvalid}, 0);
        @(posedge clk); #1;
        idle_inputs();
        for (int k = 0; k < 6; k++) begin
            s_bvalid = 1; m_bready = 1;
            @(posedge clk); #1;
        end
        idle_inputs();
        #2;
        check(m_wready, "R8", "write path reopens after drain", m_wready, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule